// File: doc/BRIEF.md
# Local Bus Arbiter with Clock-Change Masking

This block decides which of three masters owns the local processor bus that leads to SDRAM. The three masters are the CPU, the PCI host bridge and the general-purpose DMA controller. Each master has one request line and receives one grant line. Two more inputs shape the decision. A clock-change flag is raised while the core clock relocks, and the CPU can raise a write-back request when it must flush a cache line during a DMA transfer.

The DMA controller cannot be preempted. Once it holds the bus, it keeps the bus for as long as its request stays high, however long that is. The only exception is a CPU write-back, which gets the bus briefly and then hands it back to DMA. The CPU is the default owner and the bus parks on it when nobody asks for it. While the clock is changing, no new CPU grant is issued, and an idle bus belongs to no master. The PCI bridge and DMA take turns when they ask for the bus together. Every grant change passes through one cycle in which no grant is asserted.

Top module: `lbus_arbiter`

## Requirements
- R1: While reset is active and in the first cycle after it, gnt_cpu_o is 1 and gnt_pci_o and gnt_dma_o are 0.
- R2: At most one grant is high in any cycle. A change of owner always passes through at least one cycle with all grants low. Inputs are sampled on a rising clock edge, and the grants change on that same edge.
- R3: When the clock-change flag is low and no master requests the bus, the CPU grant is asserted and stays asserted (parking).
- R4: When the clock-change flag is high and no master requests the bus, all grants go low and stay low.
- R5: While the clock-change flag is high, a CPU request that does not already hold the bus gets no grant.
- R6: If the CPU holds the bus with its request high when the clock-change flag rises, it keeps its grant until its request falls. One cycle after that, all grants are low.
- R7: While the DMA grant is high and req_dma_i stays high (and wb_req_i is low), the DMA grant stays high whatever the other requests do.
- R8: The DMA grant follows the level of req_dma_i. It drops on the first edge at which the request is sampled low, so a one-cycle transfer and a long block transfer are handled alike.
- R9: A write-back request sampled while DMA owns the bus gives this sequence: a cycle with no grant, then gnt_cpu_o for as long as wb_req_i is high, then a cycle with no grant. After that, DMA is granted again if req_dma_i is still high, ahead of any PCI or CPU request.
- R10: When the bus is free and both PCI and DMA request it, they are served in turn. After reset, PCI wins the first tie.
- R11: When the bus is free, a PCI or DMA request is granted ahead of a CPU request.
- R12: wb_req_i has no effect unless a DMA transfer holds the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_cpu_i | input | 1 | CPU bus request |
| req_pci_i | input | 1 | PCI host bridge bus request |
| req_dma_i | input | 1 | DMA controller bus request (level held for the transfer) |
| wb_req_i | input | 1 | CPU cache write-back request |
| clk_chg_i | input | 1 | Core clock change in progress |
| gnt_cpu_o | output | 1 | CPU grant (also used for write-backs) |
| gnt_pci_o | output | 1 | PCI host bridge grant |
| gnt_dma_o | output | 1 | DMA controller grant |

## Verification
The hardest situation to reach from the ports is a write-back that lands inside a locked DMA transfer while PCI and CPU requests are also pending. Two things must then happen: the grant must return to DMA and not go to the waiting masters, and the lock must clear correctly if req_dma_i falls during the write-back. Directed sequences build this case step by step. Next comes a long random run that toggles each request, the write-back flag and the clock-change flag with different hold probabilities, so that long DMA blocks overlap with write-backs and with clock changes. Every cycle is compared against a model in the bench.

// File: rtl/lba_pkg.sv
package lba_pkg;
  localparam int NUM_MASTERS = 3;
  localparam int IDX_CPU     = 0;
  localparam int IDX_PCI     = 1;
  localparam int IDX_DMA     = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CPU  = 3'd1,
    ST_PCI  = 3'd2,
    ST_DMA  = 3'd3,
    ST_WB   = 3'd4
  } lba_state_e;
endpackage

// File: rtl/lba_pick.sv
module lba_pick
  import lba_pkg::*;
(
  input  logic       pci_req_i,
  input  logic       dma_req_i,
  input  logic       clk_chg_i,
  input  logic       dma_first_i,
  output lba_state_e pick_o
);
  // Choice made from a free bus: bus masters first, then the CPU (requested or parked)
  always_comb begin
    if (pci_req_i && dma_req_i) begin
      pick_o = dma_first_i ? ST_DMA : ST_PCI;
    end else if (dma_req_i) begin
      pick_o = ST_DMA;
    end else if (pci_req_i) begin
      pick_o = ST_PCI;
    end else if (!clk_chg_i) begin
      pick_o = ST_CPU;
    end else begin
      pick_o = ST_IDLE;
    end
  end
endmodule

// File: rtl/lba_rr.sv
module lba_rr (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dma_served_i,
  output logic dma_first_o
);
  logic turn_q;
  logic turn_n;

  always_comb begin
    turn_n = turn_q;
    if (en_i) begin
      turn_n = !dma_served_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= 1'b0;
    end else begin
      turn_q <= turn_n;
    end
  end

  assign dma_first_o = turn_q;
endmodule

// File: rtl/lbus_arbiter.sv
module lbus_arbiter
  import lba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_cpu_i,
  input  logic req_pci_i,
  input  logic req_dma_i,
  input  logic wb_req_i,
  input  logic clk_chg_i,
  output logic gnt_cpu_o,
  output logic gnt_pci_o,
  output logic gnt_dma_o
);
  lba_state_e             st_q, st_n, pick;
  logic                   lock_q, lock_n;
  logic [NUM_MASTERS-1:0] gnt_q, gnt_n;
  logic                   dma_first;
  logic                   rr_en;

  lba_pick u_pick (
    .pci_req_i  (req_pci_i),
    .dma_req_i  (req_dma_i),
    .clk_chg_i  (clk_chg_i),
    .dma_first_i(dma_first),
    .pick_o     (pick)
  );

  assign rr_en = (st_q == ST_IDLE) && ((st_n == ST_PCI) || (st_n == ST_DMA));

  lba_rr u_rr (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (rr_en),
    .dma_served_i(st_n == ST_DMA),
    .dma_first_o (dma_first)
  );

  // Next owner
  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_CPU: begin
        if (!req_cpu_i && (req_pci_i || req_dma_i || clk_chg_i)) st_n = ST_IDLE;
      end
      ST_PCI: begin
        if (!req_pci_i) st_n = ST_IDLE;
      end
      ST_DMA: begin
        if (!req_dma_i || wb_req_i) st_n = ST_IDLE;
      end
      ST_WB: begin
        if (!wb_req_i) st_n = ST_IDLE;
      end
      default: begin
        if (lock_q && req_dma_i) begin
          st_n = wb_req_i ? ST_WB : ST_DMA;
        end else begin
          st_n = pick;
        end
      end
    endcase
  end

  // DMA lock lasts from its grant until its request falls
  always_comb begin
    lock_n = (st_n == ST_DMA) || (lock_q && req_dma_i);
  end

  always_comb begin
    gnt_n = '0;
    case (st_n)
      ST_CPU, ST_WB: gnt_n[IDX_CPU] = 1'b1;
      ST_PCI:        gnt_n[IDX_PCI] = 1'b1;
      ST_DMA:        gnt_n[IDX_DMA] = 1'b1;
      default:       gnt_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CPU;
      lock_q <= 1'b0;
      gnt_q  <= NUM_MASTERS'(1) << IDX_CPU;
    end else begin
      st_q   <= st_n;
      lock_q <= lock_n;
      gnt_q  <= gnt_n;
    end
  end

  assign gnt_cpu_o = gnt_q[IDX_CPU];
  assign gnt_pci_o = gnt_q[IDX_PCI];
  assign gnt_dma_o = gnt_q[IDX_DMA];

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_dma_o, gnt_pci_o, gnt_cpu_o})); // R2

  AST_GAP_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0) |=> ((gnt_q == $past(gnt_q)) || (gnt_q == '0))); // R2

  AST_PARK_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0 && !req_cpu_i && !req_pci_i && !req_dma_i && !clk_chg_i) |=> gnt_cpu_o); // R3

  AST_CLKCHG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0 && !req_cpu_i && !req_pci_i && !req_dma_i && clk_chg_i) |=> (gnt_q == '0)); // R4

  AST_NO_NEW_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gnt_cpu_o) && st_q != ST_WB) |-> !$past(clk_chg_i)); // R5

  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_dma_o && req_dma_i && !wb_req_i) |=> gnt_dma_o); // R7

  AST_DMA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_dma_o && !req_dma_i) |=> !gnt_dma_o); // R8

  AST_WB_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && req_dma_i && !wb_req_i && gnt_q == '0) |=> gnt_dma_o); // R9
endmodule

// File: tb/test_lbus_arbiter.sv
module test_lbus_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic req_cpu, req_pci, req_dma, wb_req, clk_chg;
  logic gnt_cpu, gnt_pci, gnt_dma;

  int checks = 0;
  int fails  = 0;

  // model state: 0 idle, 1 cpu, 2 pci, 3 dma, 4 write-back
  int m_st;
  bit m_lock;
  bit m_dma_first;

  always #10 clk = ~clk;

  lbus_arbiter i_lbus_arbiter (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_cpu_i(req_cpu),
    .req_pci_i(req_pci),
    .req_dma_i(req_dma),
    .wb_req_i (wb_req),
    .clk_chg_i(clk_chg),
    .gnt_cpu_o(gnt_cpu),
    .gnt_pci_o(gnt_pci),
    .gnt_dma_o(gnt_dma)
  );

  function automatic logic [2:0] grant_of(int s);
    case (s)
      1, 4: return 3'b001;
      2:    return 3'b010;
      3:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int free_choice();
    if (req_pci && req_dma) return m_dma_first ? 3 : 2;
    if (req_dma) return 3;
    if (req_pci) return 2;
    if (!clk_chg) return 1;
    return 0;
  endfunction

  task automatic model_step();
    int nx;
    nx = m_st;
    if (m_st == 1) begin
      if (!req_cpu && (req_pci || req_dma || clk_chg)) nx = 0;
    end else if (m_st == 2) begin
      if (!req_pci) nx = 0;
    end else if (m_st == 3) begin
      if (!req_dma || wb_req) nx = 0;
    end else if (m_st == 4) begin
      if (!wb_req) nx = 0;
    end else begin
      if (m_lock && req_dma) nx = wb_req ? 4 : 3;
      else nx = free_choice();
      if (nx == 2 || nx == 3) m_dma_first = (nx == 2);
    end
    m_lock = (nx == 3) || (m_lock && req_dma);
    m_st = nx;
  endtask

  task automatic chk(logic [2:0] exp, string tag);
    checks++;
    if ({gnt_dma, gnt_pci, gnt_cpu} !== exp) begin
      fails++;
      $display("FAIL %s: grants(dma,pci,cpu)=%b expected %b at %0t", tag,
               {gnt_dma, gnt_pci, gnt_cpu}, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(grant_of(m_st), "R2 model");
  endtask

  task automatic drive(bit c, bit p, bit d, bit w, bit cc);
    req_cpu = c; req_pci = p; req_dma = d; wb_req = w; clk_chg = cc;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    drive(0, 0, 0, 0, 0);
    rst_n = 1'b0;
    m_st = 1; m_lock = 0; m_dma_first = 0;
    repeat (3) @(negedge clk);
    chk(3'b001, "R1 during reset");
    rst_n = 1'b1;
    chk(3'b001, "R1 after reset");

    // R3 parking
    repeat (3) step();
    chk(3'b001, "R3 parked on cpu");

    // R11 / R2 pci request from parked cpu
    drive(0, 1, 0, 0, 0);
    step(); chk(3'b000, "R2 gap before pci");
    step(); chk(3'b010, "R11 pci granted");
    repeat (2) step();
    chk(3'b010, "R11 pci held");
    drive(0, 0, 0, 0, 0);
    step(); chk(3'b000, "R2 gap after pci");
    step(); chk(3'b001, "R3 back to cpu");

    // R4 / R5 clock change
    drive(0, 0, 0, 0, 1);
    step(); chk(3'b000, "R4 no owner");
    repeat (2) step();
    chk(3'b000, "R4 stays without owner");
    drive(1, 0, 0, 0, 1);
    repeat (3) step();
    chk(3'b000, "R5 cpu masked");
    drive(1, 0, 0, 0, 0);
    step(); chk(3'b001, "R5 cpu after clock change");

    // R6 cpu keeps bus through clock change
    drive(1, 0, 0, 0, 1);
    repeat (3) step();
    chk(3'b001, "R6 cpu keeps bus");
    drive(0, 0, 0, 0, 1);
    step(); chk(3'b000, "R6 cpu released");
    drive(0, 0, 0, 0, 0);
    step(); chk(3'b001, "R3 parked again");

    // R7 / R9 dma lock and write-back
    drive(0, 0, 1, 0, 0);
    step(); chk(3'b000, "R2 gap before dma");
    step(); chk(3'b100, "R11 dma granted");
    drive(1, 1, 1, 0, 0);
    repeat (4) step();
    chk(3'b100, "R7 dma not preempted");
    drive(1, 1, 1, 1, 0);
    step(); chk(3'b000, "R9 gap before write-back");
    step(); chk(3'b001, "R9 write-back grant");
    step(); chk(3'b001, "R9 write-back held");
    drive(1, 1, 1, 0, 0);
    step(); chk(3'b000, "R9 gap after write-back");
    step(); chk(3'b100, "R9 dma regranted");
    drive(1, 1, 0, 0, 0);
    step(); chk(3'b000, "R8 dma released");
    step(); chk(3'b010, "R11 pci before cpu");
    drive(0, 0, 0, 0, 0);
    step(); chk(3'b000, "R2 gap after pci");
    step(); chk(3'b001, "R3 parked");

    // R8 single-cycle dma transfer
    drive(0, 0, 1, 0, 0);
    step(); chk(3'b000, "R8 gap");
    step(); chk(3'b100, "R8 single grant");
    drive(0, 0, 0, 0, 0);
    step(); chk(3'b000, "R8 single released");
    step(); chk(3'b001, "R3 parked");

    // R10 round robin
    drive(0, 1, 1, 0, 0);
    step(); chk(3'b000, "R10 gap");
    step(); chk(3'b010, "R10 pci wins first tie");
    drive(0, 0, 1, 0, 0);
    step(); chk(3'b000, "R10 pci dropped");
    drive(0, 1, 1, 0, 0);
    step(); chk(3'b100, "R10 dma wins next tie");
    drive(0, 1, 0, 0, 0);
    step(); chk(3'b000, "R8 dma released");
    step(); chk(3'b010, "R10 pci after dma");
    drive(0, 0, 0, 0, 0);
    repeat (2) step();
    chk(3'b001, "R3 parked");

    // R12 write-back without dma lock
    drive(0, 0, 0, 1, 0);
    repeat (2) step();
    chk(3'b001, "R12 write-back ignored while parked");
    drive(0, 0, 0, 1, 1);
    step(); chk(3'b000, "R12 clock change with write-back");
    repeat (2) step();
    chk(3'b000, "R12 write-back gives no grant");
    drive(0, 0, 0, 0, 0);
    step();

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 100 < 15) req_cpu = !req_cpu;
      if ($urandom % 100 < 12) req_pci = !req_pci;
      if ($urandom % 100 < 10) req_dma = !req_dma;
      if ($urandom % 100 < 8)  wb_req  = !wb_req;
      if ($urandom % 100 < 4)  clk_chg = !clk_chg;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule